// File: doc/BRIEF.md
# Unhalted-Time Periodic Interrupt Timer

This block raises a periodic interrupt request based on how long its processor has actually been running. A free-running 100 ns tick arrives from outside together with a status line that says whether the processor is currently halted. Only ticks that arrive while that line is low add to an internal elapsed-time accumulator. When the accumulator reaches the programmed period, the block issues a one-cycle interrupt request and sets a sticky expired flag, which software later clears.

Two registers are reachable over a simple register bus. The first is a control register that holds an enable bit and an 8-bit interrupt vector. The second is a 64-bit period register. The vector also selects the request type: vector 2 is sent as a non-maskable request, and every other vector is sent as a fixed request. Nothing in the block clears the accumulator on an interrupt. On expiry the period is subtracted from it, so any time left over carries into the next interval. Delivery of the request to an interrupt controller is handled elsewhere.

Top module: `unhalted_irq_timer`

## Requirements
- R1: The control register sits at bus address 0. Bit 8 is the enable and bits 7:0 are the vector. Every other bit reads back as zero, and the whole register resets to zero.
- R2: The period register sits at bus address 1. It is a 64-bit read/write value in 100 ns units and resets to zero.
- R3: A tick adds to the elapsed time only while `halted_i` is low. A tick taken while halted has no effect, and no request follows it.
- R4: When the timer is enabled with period P, `irq_req` rises in the cycle after the clock edge that samples the P-th counted tick. It stays high for exactly one cycle, and a further request follows every P counted ticks.
- R5: Neither an expiry nor a change of the enable bit clears the elapsed time. A disabled timer holds its count, and once re-enabled it resumes from where it stopped.
- R6: While the enable bit is 0 or the period is 0, no request is issued and counted ticks do not change the elapsed time.
- R7: `irq_vec` carries the vector together with each request. `irq_nmi` is 1 when that vector equals 2 and is 0 for any other vector.
- R8: Each request sets `flag_o`, which stays at 1 until a cycle with `flag_clr_i` high. If a clear arrives at the same edge as an expiry, the flag stays set.
- R9: If the period is lowered below the elapsed time, each counted tick produces one request until the elapsed time drops below the period. Example: with 5 units elapsed and the period then set to 2, the next five counted ticks each request, the sixth does not, and the seventh does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 1 | Write address (0 control, 1 period) |
| reg_wdata | input | 64 | Write data |
| reg_raddr | input | 1 | Read address (0 control, 1 period) |
| reg_rdata | output | 64 | Read data, combinational from `reg_raddr` |
| tick_i | input | 1 | 100 ns time tick, one cycle wide |
| halted_i | input | 1 | Processor halted status |
| flag_clr_i | input | 1 | Clears the expired flag |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_nmi | output | 1 | Request type: 1 non-maskable, 0 fixed |
| irq_vec | output | 8 | Vector of the request |
| flag_o | output | 1 | Sticky expired flag |

## Verification
A wrong elapsed-time value inside the block has no port of its own. It shows up at the next expiry, as a request that arrives one or more counted ticks too early or too late, so each scenario counts ticks up to the exact tick that should expire. A wrongly held or cleared count shows within one period of re-enabling the timer. A stuck flag or a wrong type bit shows in the cycle right after the request, and a broken catch-up shows within a few ticks of lowering the period.

// File: rtl/uit_pkg.sv
// Shared constants and types for the unhalted-time interrupt timer.
// Assumes the register bus exposes exactly two 64-bit registers.
package uit_pkg;
    localparam int ADDR_W = 1;
    localparam int VEC_W  = 8;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 1'b1;

    typedef struct packed {
        logic             en;
        logic [VEC_W-1:0] vec;
    } ctrl_t;

    typedef enum logic {
        REQ_FIXED = 1'b0,
        REQ_NMI   = 1'b1
    } req_kind_e;
endpackage

// File: rtl/uit_regs.sv
// Register file: control (enable + vector) and period.
// Assumes one write per cycle; reads are combinational and side-effect free.
module uit_regs
    import uit_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] period
);
    localparam int CTRL_W = VEC_W + 1;

    // Capture register writes; reset both registers to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            period <= '0;
        end else if (we) begin
            if (waddr == ADDR_CTRL) begin
                ctrl <= wdata[CTRL_W-1:0];
            end else begin
                period <= wdata;
            end
        end
    end

    // Read mux; unused control bits return zero.
    always_comb begin
        if (raddr == ADDR_CTRL) begin
            rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        end else begin
            rdata = period;
        end
    end
endmodule

// File: rtl/uit_accum.sv
// Elapsed-time accumulator. Adds one per qualified tick and subtracts the
// period on expiry so that leftover time carries into the next interval.
// Assumes 'run' already folds in enable and non-zero period.
module uit_accum #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             expire,
    output logic [CNT_W-1:0] acc
);
    logic [CNT_W:0] sum;
    logic [CNT_W:0] rem;

    // Next value and expiry test, one bit wider so nothing wraps.
    always_comb begin
        sum    = {1'b0, acc} + {{CNT_W{1'b0}}, 1'b1};
        rem    = sum - {1'b0, period};
        expire = run && step && (sum >= {1'b0, period});
    end

    // Advance, or advance and subtract the period; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (run && step) begin
            acc <= expire ? rem[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/uit_req.sv
// Request stage: registers the request with its type and vector and
// keeps the sticky expired flag. Set wins over a simultaneous clear.
module uit_req
    import uit_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic [VEC_W-1:0] vec,
    input  logic             clr,
    output logic             irq_req,
    output req_kind_e        kind,
    output logic [VEC_W-1:0] irq_vec,
    output logic             flag
);
    // Register the request pulse together with its type and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            kind    <= REQ_FIXED;
            irq_vec <= '0;
        end else begin
            irq_req <= expire;
            if (expire) begin
                kind    <= (vec == NMI_VEC) ? REQ_NMI : REQ_FIXED;
                irq_vec <= vec;
            end
        end
    end

    // Sticky flag: set on expiry, cleared by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/unhalted_irq_timer.sv
// Top level of the unhalted-time periodic interrupt timer.
// Assumes tick_i is a one-cycle pulse per 100 ns and halted_i is synchronous.
module unhalted_irq_timer
    import uit_pkg::*;
#(
    parameter int                DATA_W  = 64,
    parameter logic [VEC_W-1:0]  NMI_VEC = 8'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_i,
    input  logic              halted_i,
    input  logic              flag_clr_i,
    output logic              irq_req,
    output logic              irq_nmi,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              flag_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] period;
    logic [DATA_W-1:0] acc;
    logic              run;
    logic              step;
    logic              expire;
    req_kind_e         kind;

    // Qualify counting: enabled, non-zero period, running tick.
    always_comb begin
        run     = ctrl.en && (period != '0);
        step    = tick_i && !halted_i;
        irq_nmi = (kind == REQ_NMI);
    end

    uit_regs #(.DATA_W(DATA_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .waddr  (reg_waddr),
        .wdata  (reg_wdata),
        .raddr  (reg_raddr),
        .rdata  (reg_rdata),
        .ctrl   (ctrl),
        .period (period)
    );

    uit_accum #(.CNT_W(DATA_W)) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .step   (step),
        .period (period),
        .expire (expire),
        .acc    (acc)
    );

    uit_req #(.NMI_VEC(NMI_VEC)) req_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .vec     (ctrl.vec),
        .clr     (flag_clr_i),
        .irq_req (irq_req),
        .kind    (kind),
        .irq_vec (irq_vec),
        .flag    (flag_o)
    );
endmodule

// File: rtl/unhalted_irq_timer_chk.sv
// Property checker for the unhalted-time timer, bound to the top module.
module unhalted_irq_timer_chk
    import uit_pkg::*;
#(
    parameter int               DATA_W  = 64,
    parameter logic [VEC_W-1:0] NMI_VEC = 8'd2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_raddr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              tick_i,
    input logic              halted_i,
    input logic              flag_clr_i,
    input logic              irq_req,
    input logic              irq_nmi,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              flag_o,
    input logic              en,
    input logic              run,
    input logic [DATA_W-1:0] acc
);
    a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_raddr == ADDR_CTRL) |-> ((reg_rdata >> (VEC_W + 1)) == '0));

    a_r3_halted_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && !halted_i) |=> !irq_req);

    a_r5_acc_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick_i && !halted_i) |=> $stable(acc));

    a_r6_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq_req);

    a_r7_req_type: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_nmi == (irq_vec == NMI_VEC)));

    a_r8_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> flag_o);

    a_r8_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(flag_clr_i));
endmodule

bind unhalted_irq_timer unhalted_irq_timer_chk #(.DATA_W(DATA_W), .NMI_VEC(NMI_VEC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_raddr  (reg_raddr),
    .reg_rdata  (reg_rdata),
    .tick_i     (tick_i),
    .halted_i   (halted_i),
    .flag_clr_i (flag_clr_i),
    .irq_req    (irq_req),
    .irq_nmi    (irq_nmi),
    .irq_vec    (irq_vec),
    .flag_o     (flag_o),
    .en         (ctrl.en),
    .run        (run),
    .acc        (acc)
);

// File: tb/unhalted_irq_timer_tb_top.sv
`timescale 1ns/1ps
module unhalted_irq_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_waddr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic        reg_raddr = 1'b0;
    logic [63:0] reg_rdata;
    logic        tick_i = 1'b0;
    logic        halted_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic        irq_req;
    logic        irq_nmi;
    logic [7:0]  irq_vec;
    logic        flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    unhalted_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .tick_i(tick_i), .halted_i(halted_i), .flag_clr_i(flag_clr_i),
        .irq_req(irq_req), .irq_nmi(irq_nmi), .irq_vec(irq_vec), .flag_o(flag_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [63:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // One tick; the request, if any, is visible at the following negedge.
    task automatic tick(input bit h, input bit clr, output bit got);
        @(negedge clk);
        tick_i = 1'b1; halted_i = h; flag_clr_i = clr;
        @(negedge clk);
        tick_i = 1'b0; halted_i = 1'b0; flag_clr_i = 1'b0;
        got = irq_req;
    endtask

    task automatic expect_ticks(input int n, input int p_fire, input string tag);
        bit got;
        for (int i = 1; i <= n; i++) begin
            tick(1'b0, 1'b0, got);
            check(got == (i == p_fire), tag, got, (i == p_fire));
        end
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(1'b0, d); check(d == 0, "R1 ctrl reset", d, 0);
        rd(1'b1, d); check(d == 0, "R2 period reset", d, 0);
        check(irq_req == 0 && flag_o == 0, "R8 outputs reset", {irq_req, flag_o}, 0);
    endtask

    task automatic t_regs();
        logic [63:0] d;
        wr(1'b0, 64'hFFFF_FFFF_FFFF_FEAB);
        rd(1'b0, d); check(d == 64'h0AB, "R1 ctrl readback", d, 64'h0AB);
        wr(1'b1, 64'h1234_5678_9ABC_DEF0);
        rd(1'b1, d); check(d == 64'h1234_5678_9ABC_DEF0, "R2 period readback", d, 64'h1234_5678_9ABC_DEF0);
        wr(1'b0, 0);
        wr(1'b1, 0);
    endtask

    task automatic t_period();
        bit got;
        wr(1'b1, 3);
        wr(1'b0, 64'h140);
        expect_ticks(2, 0, "R4 before expiry");
        tick(1'b0, 1'b0, got);
        check(got, "R4 third tick", got, 1);
        check(irq_vec == 8'h40 && !irq_nmi, "R7 fixed type", {irq_nmi, irq_vec}, 9'h040);
        @(negedge clk);
        check(!irq_req, "R4 one cycle wide", irq_req, 0);
        expect_ticks(3, 3, "R4 second period");
    endtask

    task automatic t_halted();
        bit got;
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, 1'b0, got);
            check(!got, "R3 halted tick", got, 0);
        end
        expect_ticks(3, 3, "R3 running ticks");
    endtask

    task automatic t_disable();
        bit got;
        expect_ticks(2, 0, "R5 partial");
        wr(1'b0, 64'h040);
        for (int i = 0; i < 6; i++) begin
            tick(1'b0, 1'b0, got);
            check(!got, "R6 disabled", got, 0);
        end
        wr(1'b0, 64'h140);
        expect_ticks(1, 1, "R5 resume held count");
        wr(1'b1, 0);
        for (int i = 0; i < 6; i++) begin
            tick(1'b0, 1'b0, got);
            check(!got, "R6 zero period", got, 0);
        end
        wr(1'b1, 3);
        expect_ticks(3, 3, "R6 count held at zero period");
    endtask

    task automatic t_nmi();
        bit got;
        wr(1'b0, 64'h102);
        expect_ticks(2, 0, "R7 pre");
        tick(1'b0, 1'b0, got);
        check(got && irq_nmi && irq_vec == 2, "R7 vector 2 nmi", {got, irq_nmi, irq_vec}, {2'b11, 8'h02});
        wr(1'b0, 64'h103);
        expect_ticks(2, 0, "R7 pre");
        tick(1'b0, 1'b0, got);
        check(got && !irq_nmi && irq_vec == 3, "R7 vector 3 fixed", {got, irq_nmi, irq_vec}, {2'b10, 8'h03});
    endtask

    task automatic t_flag();
        bit got;
        check(flag_o, "R8 flag set", flag_o, 1);
        @(negedge clk); flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        check(!flag_o, "R8 flag clear", flag_o, 0);
        expect_ticks(2, 0, "R8 pre");
        check(!flag_o, "R8 flag stays clear", flag_o, 0);
        tick(1'b0, 1'b0, got);
        check(flag_o, "R8 flag set again", flag_o, 1);
        expect_ticks(2, 0, "R8 pre");
        tick(1'b0, 1'b1, got);
        check(got && flag_o, "R8 set wins over clear", {got, flag_o}, 2'b11);
    endtask

    task automatic t_catchup();
        bit got;
        bit exp_pat [7] = '{1, 1, 1, 1, 1, 0, 1};
        wr(1'b1, 100);
        expect_ticks(5, 0, "R9 build up");
        wr(1'b1, 2);
        for (int i = 0; i < 7; i++) begin
            tick(1'b0, 1'b0, got);
            check(got == exp_pat[i], "R9 catch-up", got, exp_pat[i]);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_period();
        t_halted();
        t_disable();
        t_nmi();
        t_flag();
        t_catchup();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule